// File: doc/BRIEF.md
# Comparator Interrupt Control Register

This block is the digital side of an on-chip voltage comparator. It brings the comparator's raw output into the clock domain and shows it as a live status bit. It watches that bit for a chosen kind of edge and latches each qualifying edge into a sticky interrupt flag. The flag can be masked locally and globally before it becomes an interrupt request. Software clears the flag by writing one to its bit. The interrupt controller can also clear it with an acknowledge pulse when it takes the vector for this source.

All control and status sits in one 8-bit register. The register also holds two controls that go straight to the analog side. One powers the comparator down. The other switches the comparator's positive input from the external pin to an internal fixed reference. The comparator, the reference and the interrupt controller sit outside this block and appear only as ports.

The register's bit positions are fixed: 7 is power-down, 6 is reference select, 5 is the live result, 4 is the flag, 3 is the local enable, 2 is reserved, and 1:0 select the edge mode.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset every register bit reads zero, including the live result while the comparator input is low; `irq_req`, `cmp_disable` and `ref_sel` are low.
- R2: Bit 5 shows the comparator input two clock edges after the input changes, and writing that bit has no effect.
- R3: Bits 7, 6, 3, 1 and 0 read back the value last written. Bit 2 always reads zero, even after a one is written to it.
- R4: With mode 11, a rising edge of the comparator input sets the flag (bit 4), visible three clock edges after the input change; a falling edge does not set it.
- R5: With mode 10, a falling edge sets the flag with the same latency; a rising edge does not.
- R6: With mode 00, both rising and falling edges set the flag.
- R7: Mode 01 is reserved and produces no flag events on either edge.
- R8: A write with bit 4 at one clears the flag at that clock edge; a write with bit 4 at zero leaves the flag unchanged.
- R9: A one-cycle pulse on `irq_ack` clears the flag.
- R10: When an edge event and a clear (write-one or acknowledge) fall on the same clock edge, the flag ends up set.
- R11: `irq_req` is high exactly when the flag, the local enable (bit 3) and `gie` are all one.
- R12: While bit 7 is one, `cmp_disable` is high, bit 5 reads zero and no edge sets the flag; `ref_sel` follows bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Unsynchronized comparator output, high when positive input exceeds negative |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq_ack | input | 1 | Vector acknowledge from the interrupt controller |
| irq_req | output | 1 | Interrupt request |
| cmp_disable | output | 1 | Comparator power-down to the analog side |
| ref_sel | output | 1 | Positive-input reference select to the analog multiplexer |

## Verification
A comparator change reaches bit 5 after two clock edges and the flag after three. The bench changes the input on a falling edge, waits that exact number of rising edges, and samples on the next falling edge. Writes, acknowledges and register controls act at the single rising edge that follows their setup. `irq_req`, `cmp_disable`, `ref_sel` and the forced-low result under disable are combinational from state and are checked in the half cycle after that edge. The same-edge collision is built by placing the acknowledge in the one cycle where the edge event is pending, which is the third rising edge after the input change.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int REG_W = 8;

  localparam int BIT_DIS  = 7;
  localparam int BIT_REF  = 6;
  localparam int BIT_LIVE = 5;
  localparam int BIT_FLAG = 4;
  localparam int BIT_EN   = 3;
  localparam int BIT_RSVD = 2;
  localparam int BIT_MODE = 0;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_NONE   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic force_low,
  output logic dout
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1] & ~force_low;
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic       block,
  input  edge_mode_e mode,
  output logic       evt
);
  logic prev_q;
  logic rise;
  logic fall;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  always_comb begin
    unique case (mode)
      MODE_TOGGLE: hit = rise | fall;
      MODE_FALL:   hit = fall;
      MODE_RISE:   hit = rise;
      default:     hit = 1'b0;
    endcase
  end

  assign evt = hit & ~block;

  AST_RSVD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NONE) |-> !evt); // R7
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_sw,
  input  logic clr_ack,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic clr_any;

  assign clr_any = clr_sw | clr_ack;

  always_comb begin
    flag_d = flag_q;
    if (set_evt) begin
      flag_d = 1'b1;
    end else if (clr_any) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !set_evt) |=> !flag_q); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any && !set_evt) |=> $stable(flag_q)); // R8
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             gie,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             cmp_disable,
  output logic             ref_sel
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic              dis_q, dis_d;
  logic              ref_q, ref_d;
  logic              en_q, en_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              ctrl_we;

  assign ctrl_we = wr_en;

  always_comb begin
    dis_d  = dis_q;
    ref_d  = ref_q;
    en_d   = en_q;
    mode_d = mode_q;
    if (ctrl_we) begin
      dis_d  = wr_data[BIT_DIS];
      ref_d  = wr_data[BIT_REF];
      en_d   = wr_data[BIT_EN];
      mode_d = wr_data[BIT_MODE +: MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dis_q  <= 1'b0;
      ref_q  <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      dis_q  <= dis_d;
      ref_q  <= ref_d;
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  logic live;
  logic evt;
  logic flag;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .din       (cmp_raw),
    .force_low (dis_q),
    .dout      (live)
  );

  cmp_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_int_n),
    .level (live),
    .block (dis_q),
    .mode  (edge_mode_e'(mode_q)),
    .evt   (evt)
  );

  cmp_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_evt (evt),
    .clr_sw  (wr_en & wr_data[BIT_FLAG]),
    .clr_ack (irq_ack),
    .flag    (flag)
  );

  always_comb begin
    rd_data                       = '0;
    rd_data[BIT_DIS]              = dis_q;
    rd_data[BIT_REF]              = ref_q;
    rd_data[BIT_LIVE]             = live;
    rd_data[BIT_FLAG]             = flag;
    rd_data[BIT_EN]               = en_q;
    rd_data[BIT_MODE +: MODE_W]   = mode_q;
  end

  assign irq_req     = flag & en_q & gie;
  assign cmp_disable = dis_q;
  assign ref_sel     = ref_q;

  AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_req |-> (gie && rd_data[BIT_EN] && rd_data[BIT_FLAG])); // R11
  AST_DIS_LIVE_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_disable |-> !rd_data[BIT_LIVE]); // R12
  AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmp_disable && !rd_data[BIT_FLAG]) |=> !rd_data[BIT_FLAG]); // R12
endmodule

// File: tb/tb_cmp_irq_ctrl.sv
module tb_cmp_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_raw;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       gie;
  logic       irq_ack;
  logic       irq_req;
  logic       cmp_disable;
  logic       ref_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmp_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .gie(gie), .irq_ack(irq_ack),
    .irq_req(irq_req), .cmp_disable(cmp_disable), .ref_sel(ref_sel)
  );

  // {mode[1:0], final input level, expected flag}; start level is the inverse
  localparam logic [3:0] VEC [0:7] = '{
    4'b11_1_1, 4'b11_0_0, 4'b10_1_0, 4'b10_0_1,
    4'b00_1_1, 4'b00_0_1, 4'b01_1_0, 4'b01_0_0
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    edges(1);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmp_raw = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    gie = 1'b0; irq_ack = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(4);

    // R1
    check(rd_data, 8'h00, "R1 register");
    check({5'd0, irq_req, cmp_disable, ref_sel}, 8'h00, "R1 outputs");

    // R3 readback and reserved bit
    reg_write(8'b0100_0111);
    check(rd_data, 8'b0100_0011, "R3 readback with bit 2 written");
    check({7'd0, ref_sel}, 8'h01, "R12 ref_sel follows bit 6");
    reg_write(8'h00);
    check(rd_data, 8'h00, "R3 cleared");

    // R2 live result latency and read-only
    cmp_raw = 1'b1;
    edges(1);
    check({7'd0, rd_data[5]}, 8'h00, "R2 not yet after one edge");
    edges(1);
    check({7'd0, rd_data[5]}, 8'h01, "R2 live after two edges");
    reg_write(8'b0000_0001);
    check({7'd0, rd_data[5]}, 8'h01, "R2 write zero ignored");
    cmp_raw = 1'b0;
    edges(4);
    reg_write(8'b0011_0001);
    check({7'd0, rd_data[5]}, 8'h00, "R2 write one ignored");

    // R4 R5 R6 R7 edge mode table
    foreach (VEC[k]) begin
      reg_write({3'b000, 1'b1, 2'b00, VEC[k][3:2]});
      cmp_raw = ~VEC[k][1];
      edges(4);
      reg_write({3'b000, 1'b1, 2'b00, VEC[k][3:2]});
      check({7'd0, rd_data[4]}, 8'h00, "R8 table pre-clear");
      cmp_raw = VEC[k][1];
      edges(2);
      check({7'd0, rd_data[4]}, 8'h00, $sformatf("R4 R5 R6 R7 vec%0d early", k));
      edges(1);
      check({7'd0, rd_data[4]}, {7'd0, VEC[k][0]},
            $sformatf("R4 R5 R6 R7 vec%0d mode=%b to=%b", k, VEC[k][3:2], VEC[k][1]));
    end

    // leave: mode 01, raw 0, flag 0. Toggle mode, set flag.
    reg_write(8'b0001_0000);
    cmp_raw = 1'b1;
    edges(3);
    check({7'd0, rd_data[4]}, 8'h01, "R6 flag set for W1C test");

    // R8 write zero keeps flag
    reg_write(8'b0000_0000);
    check({7'd0, rd_data[4]}, 8'h01, "R8 write zero keeps flag");

    // R11 request gating
    gie = 1'b1;
    edges(1);
    check({7'd0, irq_req}, 8'h00, "R11 local enable off");
    reg_write(8'b0000_1000);
    check({7'd0, irq_req}, 8'h01, "R11 all set");
    gie = 1'b0;
    edges(1);
    check({7'd0, irq_req}, 8'h00, "R11 gie off");
    gie = 1'b1;

    // R8 write one clears
    reg_write(8'b0001_1000);
    check({7'd0, rd_data[4]}, 8'h00, "R8 write one clears");
    check({7'd0, irq_req}, 8'h00, "R11 flag off");

    // R9 acknowledge clears
    cmp_raw = 1'b0;
    edges(3);
    check({7'd0, irq_req}, 8'h01, "R11 request after falling toggle");
    irq_ack = 1'b1;
    edges(1);
    irq_ack = 1'b0;
    check({7'd0, rd_data[4]}, 8'h00, "R9 ack clears");

    // R10 ack on the event edge
    cmp_raw = 1'b1;
    edges(2);
    irq_ack = 1'b1;
    edges(1);
    irq_ack = 1'b0;
    check({7'd0, rd_data[4]}, 8'h01, "R10 set beats ack");
    irq_ack = 1'b1;
    edges(1);
    irq_ack = 1'b0;
    check({7'd0, rd_data[4]}, 8'h00, "R9 ack alone");

    // R10 write-one on the event edge
    cmp_raw = 1'b0;
    edges(1);
    @(posedge clk);
    @(negedge clk);
    reg_write(8'b0001_1000);
    check({7'd0, rd_data[4]}, 8'h01, "R10 set beats write one");
    reg_write(8'b0001_1000);

    // R12 disable
    cmp_raw = 1'b1;
    edges(3);
    reg_write(8'b0001_1000);
    check({7'd0, rd_data[5]}, 8'h01, "R2 live high before disable");
    reg_write(8'b1000_1000);
    check({6'd0, cmp_disable, rd_data[5]}, 8'h02, "R12 disable forces live low");
    edges(1);
    check({7'd0, rd_data[4]}, 8'h00, "R12 no flag on disable");
    for (int t = 0; t < 4; t++) begin
      cmp_raw = ~cmp_raw;
      edges(3);
    end
    check({7'd0, rd_data[4]}, 8'h00, "R12 no flag while disabled");
    cmp_raw = 1'b0;
    edges(3);
    reg_write(8'b0000_1000);
    edges(2);
    check({6'd0, cmp_disable, rd_data[4]}, 8'h00, "R12 re-enable quiet");

    // R1 reset again mid-run
    rst_n = 1'b0;
    edges(1);
    check(rd_data, 8'h00, "R1 reset mid-run");
    rst_n = 1'b1;
    edges(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule